// File: doc/BRIEF.md
# Shared-Port 16-bit Register Processor

This block is a compact 16-bit processor with eight general registers that reaches program and data through one memory port. Every instruction is a single 16-bit word. Register moves, arithmetic and branches finish in one clock, and the fetch of the following instruction happens in that same clock. A load or a store needs the port for its data, so it takes two clocks. The first clock carries the data transfer. The second clock fetches the next instruction.

Each instruction and cycle is decoded into a set of control signals. One of these is a "final cycle" bit. When that bit is set, the instruction register captures the word on the read-data input and the program counter advances. When it is clear, the instruction register keeps its value and a one-bit step register is set, so that the instruction runs a second cycle. The step register returns to 0 when the instruction completes.

The memory outside the block returns read data for the address driven in the same cycle, and it performs writes on the rising clock edge. The block has no halt instruction. Once a program ends it keeps running through memory, so a program normally finishes in a self-loop.

Top module: `ucpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register, the step register and all eight registers. In the first cycle after reset the block fetches from address 0 with write enable low.
- R2: The instruction word is split as follows. Bits 15:12 hold the opcode, bits 11:9 the destination register, bit 8 the immediate-select flag and bits 7:0 the low byte. In register form the source register is bits 2:0 and bits 7:3 are ignored.
- R3: Opcode 0 (move) writes the zero-extended low byte to the destination when the flag is 1. When the flag is 0 it writes the source register.
- R4: Opcode 1 (add) and opcode 2 (subtract) replace the destination with the destination plus or minus the operand, modulo 2^16. In immediate form the operand is only bits 3:0, zero-extended.
- R5: Opcode 4 (store) takes two cycles. In the first cycle the block drives address = low byte, write data = destination register and write enable = 1. In the second cycle it fetches from the next sequential address.
- R6: Opcode 3 (load) takes two cycles. In the first cycle it drives address = low byte and writes the returned word to the destination. In the second cycle it fetches the next instruction.
- R7: Opcode 5 jumps when the destination register is zero, and opcode 6 jumps when it is non-zero. A taken jump fetches from the low byte in the same cycle. A jump that is not taken fetches sequentially. Both cases take one cycle.
- R8: Opcodes 7 to 15 change no register and no memory, and they take one cycle.
- R9: The program counter advances by one on each fetch and wraps from 255 to 0.
- R10: An iterative Fibonacci program in memory stores the expected sequence and leaves the expected final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Shared address for fetch and data |
| mem_wdata | output | DATA_W | Store data |
| mem_we | output | 1 | Write enable, high in a store's data cycle |
| mem_rdata | input | DATA_W | Read data for mem_addr in the current cycle |

## Verification
The bench builds the block with its default values, DATA_W = 16 and ADDR_W = 8. An 8-bit address covers the whole 256-word memory that the bench models. This makes it practical to place a jump near the top of memory and watch the counter wrap back to address 0. The same 8-bit width is also the width of the low-byte immediate. So every store, load and jump target in the directed programs reaches real memory, and the bench can compare the address trace cycle by cycle.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

    localparam int INSN_W = 16;
    localparam int RIDX_W = 3;
    localparam int NUM_REGS = 1 << RIDX_W;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_LDW = 4'd3,
        OP_STW = 4'd4,
        OP_JZ  = 4'd5,
        OP_JNZ = 4'd6
    } op_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic              imm_sel;
        logic [7:0]        lo8;
    } insn_t;

    typedef struct packed {
        logic    last;      // instruction ends this cycle
        logic    data_cyc;  // port carries a data access
        logic    mem_we;
        logic    reg_we;
        logic    from_mem;  // register write takes read data
        logic    is_jump;
        alu_op_e alu;
    } ctrl_t;

    function automatic ctrl_t decode(op_e op, logic step);
        ctrl_t c;
        c      = '0;
        c.last = 1'b1;
        if (!step) begin
            case (op)
                OP_MOV: begin c.reg_we = 1'b1; c.alu = ALU_PASS; end
                OP_ADD: begin c.reg_we = 1'b1; c.alu = ALU_ADD;  end
                OP_SUB: begin c.reg_we = 1'b1; c.alu = ALU_SUB;  end
                OP_LDW: begin
                    c.last = 1'b0; c.data_cyc = 1'b1;
                    c.reg_we = 1'b1; c.from_mem = 1'b1;
                end
                OP_STW: begin
                    c.last = 1'b0; c.data_cyc = 1'b1; c.mem_we = 1'b1;
                end
                OP_JZ, OP_JNZ: c.is_jump = 1'b1;
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/ucpu_regfile.sv
module ucpu_regfile #(
    parameter int NREGS  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata)); // R3
endmodule

// File: rtl/ucpu_alu.sv
module ucpu_alu
    import ucpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/ucpu_ctrl.sv
module ucpu_ctrl
    import ucpu_pkg::*;
(
    input  op_e   op,
    input  logic  step,
    input  logic  rd_zero,
    output ctrl_t ctl,
    output logic  take_jump
);
    always_comb begin
        ctl       = decode(op, step);
        take_jump = ctl.is_jump && ((op == OP_JZ) == rd_zero);
    end
endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
    import ucpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    insn_t             ir_q;
    logic [ADDR_W-1:0] pc_q;
    logic              step_q;

    ctrl_t             ctl;
    logic              take_jump;
    logic [DATA_W-1:0] rd_val, rs_val, opnd, alu_y, reg_wdata;
    logic [ADDR_W-1:0] fetch_addr, imm_addr;

    ucpu_regfile #(.NREGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.reg_we),
        .waddr   (ir_q.rd),
        .wdata   (reg_wdata),
        .raddr_a (ir_q.rd),
        .raddr_b (ir_q.lo8[RIDX_W-1:0]),
        .rdata_a (rd_val),
        .rdata_b (rs_val)
    );

    ucpu_ctrl u_ctrl (
        .op        (ir_q.op),
        .step      (step_q),
        .rd_zero   (rd_val == '0),
        .ctl       (ctl),
        .take_jump (take_jump)
    );

    // move takes the full low byte; add and subtract take its low nibble
    always_comb begin
        if (!ir_q.imm_sel)          opnd = rs_val;
        else if (ir_q.op == OP_MOV) opnd = DATA_W'(ir_q.lo8);
        else                        opnd = DATA_W'(ir_q.lo8[3:0]);
    end

    ucpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctl.alu),
        .a  (rd_val),
        .b  (opnd),
        .y  (alu_y)
    );

    assign reg_wdata  = ctl.from_mem ? mem_rdata : alu_y;
    assign imm_addr   = ADDR_W'(ir_q.lo8);
    assign fetch_addr = take_jump ? imm_addr : pc_q;
    assign mem_addr   = ctl.data_cyc ? imm_addr : fetch_addr;
    assign mem_wdata  = rd_val;
    assign mem_we     = ctl.mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            step_q <= 1'b0;
        end else if (ctl.last) begin
            ir_q   <= insn_t'(mem_rdata[INSN_W-1:0]);
            pc_q   <= fetch_addr + ADDR_W'(1);
            step_q <= 1'b0;
        end else begin
            step_q <= 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && ir_q == '0 && !step_q)); // R1
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_q |=> !step_q); // R5
    AST_IR_HELD: assert property (@(posedge clk) disable iff (rst)
        step_q |-> $stable(ir_q)); // R6
    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (step_q && !mem_we && mem_addr == $past(pc_q))); // R5
    AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
        (ctl.last && !take_jump) |=> pc_q == $past(pc_q) + ADDR_W'(1)); // R9
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        take_jump |=> pc_q == ADDR_W'($past(ir_q.lo8)) + ADDR_W'(1)); // R7
endmodule

// File: tb/ucpu_core_test.sv
`timescale 1ns/1ps
module ucpu_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [15:0] mem [0:255];
    logic [7:0]  exp_tr [0:15];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ucpu_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    function automatic logic [15:0] enc(logic [3:0] op, logic [2:0] rd,
                                        logic c, logic [7:0] lo);
        return {op, rd, c, lo};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // leaves time at the negedge of the first cycle after reset
    task automatic go();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic trace(string tag, int n);
        for (int i = 0; i < n; i++) begin
            check(tag, {8'h00, mem_addr}, {8'h00, exp_tr[i]});
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        clear_mem();
        mem[0] = enc(4'd0, 3'd1, 1'b1, 8'h77);
        mem[1] = enc(4'd5, 3'd6, 1'b1, 8'h01);
        go();
        check("R1 first fetch address", {8'h00, mem_addr}, 16'h0000);
        check("R1 write enable after reset", {15'h0, mem_we}, 16'h0000);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 address during reset", {8'h00, mem_addr}, 16'h0000);
        clear_mem();
        mem[0]     = enc(4'd4, 3'd1, 1'b1, 8'h50);
        mem[1]     = enc(4'd5, 3'd6, 1'b1, 8'h01);
        mem[8'h50] = 16'hDEAD;
        go();
        repeat (8) @(negedge clk);
        check("R1 register cleared by reset", mem[8'h50], 16'h0000);
    endtask

    task automatic test_store_timing();
        clear_mem();
        mem[0] = enc(4'd0, 3'd1, 1'b1, 8'h2A);
        mem[1] = enc(4'd4, 3'd1, 1'b1, 8'h40);
        go();
        exp_tr[0] = 8'h00; exp_tr[1] = 8'h01;
        @(negedge clk);
        @(negedge clk);
        check("R5 store data address", {8'h00, mem_addr}, 16'h0040);
        check("R5 store write enable", {15'h0, mem_we}, 16'h0001);
        check("R5 store write data", mem_wdata, 16'h002A);
        @(negedge clk);
        check("R5 fetch after store", {8'h00, mem_addr}, 16'h0002);
        check("R5 no write in fetch cycle", {15'h0, mem_we}, 16'h0000);
        @(negedge clk);
        check("R9 sequential fetch", {8'h00, mem_addr}, 16'h0003);
    endtask

    task automatic test_alu();
        clear_mem();
        mem[0]  = enc(4'd0, 3'd1, 1'b1, 8'hC8);
        mem[1]  = enc(4'd0, 3'd2, 1'b0, 8'h01);
        mem[2]  = enc(4'd1, 3'd2, 1'b1, 8'hF3);
        mem[3]  = enc(4'd1, 3'd2, 1'b0, 8'h01);
        mem[4]  = enc(4'd2, 3'd3, 1'b1, 8'h01);
        mem[5]  = enc(4'd0, 3'd4, 1'b1, 8'h55);
        mem[6]  = enc(4'd2, 3'd4, 1'b0, 8'hF9);
        mem[7]  = enc(4'd4, 3'd2, 1'b1, 8'h80);
        mem[8]  = enc(4'd4, 3'd3, 1'b1, 8'h81);
        mem[9]  = enc(4'd4, 3'd4, 1'b1, 8'h82);
        mem[10] = enc(4'd4, 3'd1, 1'b1, 8'h83);
        mem[11] = enc(4'd5, 3'd6, 1'b1, 8'h0B);
        go();
        repeat (30) @(negedge clk);
        check("R4 add nibble immediate and register", mem[8'h80], 16'd403);
        check("R4 subtract wraps below zero", mem[8'h81], 16'hFFFF);
        check("R2 register form ignores bits 7:3", mem[8'h82], 16'hFF8D);
        check("R3 move of full low byte", mem[8'h83], 16'h00C8);
    endtask

    task automatic test_load_jump_nop();
        int writes = 0;
        clear_mem();
        mem[8'h90] = 16'h1234;
        mem[0]  = enc(4'd3, 3'd5, 1'b1, 8'h90);
        mem[1]  = enc(4'd1, 3'd5, 1'b1, 8'h01);
        mem[2]  = enc(4'd7, 3'd5, 1'b1, 8'hFF);
        mem[3]  = enc(4'd15, 3'd5, 1'b1, 8'h01);
        mem[4]  = enc(4'd6, 3'd6, 1'b1, 8'h20);
        mem[5]  = enc(4'd5, 3'd6, 1'b1, 8'h07);
        mem[6]  = enc(4'd0, 3'd5, 1'b1, 8'h00);
        mem[7]  = enc(4'd6, 3'd5, 1'b1, 8'h09);
        mem[8]  = enc(4'd0, 3'd5, 1'b1, 8'h00);
        mem[9]  = enc(4'd4, 3'd5, 1'b1, 8'hA0);
        mem[10] = enc(4'd5, 3'd6, 1'b1, 8'h0A);
        exp_tr[0] = 8'h00; exp_tr[1] = 8'h90; exp_tr[2] = 8'h01;
        exp_tr[3] = 8'h02; exp_tr[4] = 8'h03; exp_tr[5] = 8'h04;
        exp_tr[6] = 8'h05; exp_tr[7] = 8'h07; exp_tr[8] = 8'h09;
        exp_tr[9] = 8'hA0; exp_tr[10] = 8'h0A;
        go();
        for (int i = 0; i < 11; i++) begin
            if (mem_we) writes++;
            check("R6 R7 R8 address trace", {8'h00, mem_addr}, {8'h00, exp_tr[i]});
            @(negedge clk);
        end
        repeat (10) begin
            if (mem_we) writes++;
            @(negedge clk);
        end
        check("R6 loaded value plus one", mem[8'hA0], 16'h1235);
        check("R8 undefined opcodes write no memory", 16'(writes), 16'd1);
    endtask

    task automatic test_wrap();
        clear_mem();
        mem[0] = enc(4'd5, 3'd6, 1'b1, 8'hFE);
        exp_tr[0] = 8'h00; exp_tr[1] = 8'hFE; exp_tr[2] = 8'hFF;
        exp_tr[3] = 8'h00; exp_tr[4] = 8'hFE;
        go();
        trace("R9 counter wraps, R7 taken jump", 5);
    endtask

    task automatic test_fib();
        logic [15:0] a = 16'd0, b = 16'd1, t;
        logic [15:0] seq [0:8];
        int k = 0;
        for (int i = 0; i < 9; i++) begin
            seq[i] = a; t = a; a = b; b = b + t;
        end
        clear_mem();
        mem[0]  = enc(4'd0, 3'd0, 1'b1, 8'd0);
        mem[1]  = enc(4'd0, 3'd1, 1'b1, 8'd1);
        mem[2]  = enc(4'd0, 3'd7, 1'b1, 8'd9);
        mem[3]  = enc(4'd5, 3'd7, 1'b1, 8'd10);
        mem[4]  = enc(4'd4, 3'd0, 1'b1, 8'hF0);
        mem[5]  = enc(4'd0, 3'd2, 1'b0, 8'd0);
        mem[6]  = enc(4'd0, 3'd0, 1'b0, 8'd1);
        mem[7]  = enc(4'd1, 3'd1, 1'b0, 8'd2);
        mem[8]  = enc(4'd2, 3'd7, 1'b1, 8'd1);
        mem[9]  = enc(4'd6, 3'd7, 1'b1, 8'd4);
        mem[10] = enc(4'd4, 3'd0, 1'b1, 8'hF1);
        mem[11] = enc(4'd4, 3'd1, 1'b1, 8'hF2);
        mem[12] = enc(4'd5, 3'd6, 1'b1, 8'd12);
        go();
        for (int c = 0; c < 200; c++) begin
            if (mem_we && mem_addr == 8'hF0) begin
                if (k < 9) check("R10 stored sequence", mem_wdata, seq[k]);
                k++;
            end
            @(negedge clk);
        end
        check("R10 store count", 16'(k), 16'd9);
        check("R10 final R0", mem[8'hF1], a);
        check("R10 final R1", mem[8'hF2], b);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_store_timing();
        test_alu();
        test_load_jump_nop();
        test_wrap();
        test_fib();
        finish_run();
    end
endmodule